// File: doc/BRIEF.md
# SDRAM Row Open and Column Launch Controller

This block drives the command pins of one group of SDRAM banks that belongs to a single memory module pair. A memory sequencer presents a target (bank index, row, column and the high physical address bits) together with a row-open request and, once it is ready to move data, one of three transfer requests: read, write or read-for-merge. The block checks whether the high address bits fall inside the window configured for this pair. It keeps the open row of every bank and issues whichever of precharge, activate, read or write the request needs next.

The row-open request is speculative. The sequencer may hold it for a while and then withdraw it without moving any data, and the block never reports that a row has finished opening. A transfer request that arrives before its row is open is held back until the activate-to-column spacing has elapsed. The cycle the column command goes out, a one-cycle launch strobe is returned. After a read or a write, an external keep/close hint decides whether the bank is precharged once the burst ends. A read-for-merge ignores the hint and always leaves the row open for the write that is expected to follow.

Top module: `sdram_row_launch`

## Requirements
- R1: While reset is held, and after it is released with no request, the pins {cs_n,ras_n,cas_n,we_n} read 4'b1111 (deselect), and cas_asserted and nxm are 0.
- R2: The pair matches when cfg_en is 1 and cfg_base <= hi_addr < cfg_base + 2^cfg_size. When any request is present and there is no match, nxm is 1 in the following cycle and no command is issued for that request. When there is no request, nxm is 0.
- R3: A row-open request to a bank with no open row issues an activate (pins 4'b0011) one cycle later, with the bank on cmd_bank and the row on cmd_addr.
- R4: A request to a bank that already has the requested row open issues no command.
- R5: A request to a bank holding a different row issues a precharge (pins 4'b0010) first, and then an activate of the new row T_RP cycles later. An activate never follows a precharge to the same bank in the next cycle.
- R6: A row-open request that is withdrawn leaves no further commands and no launch strobe. cas_asserted is never 1 in the cycle after one with no transfer request.
- R7: A transfer request to a bank whose row is not yet open is delayed. Its column command (read 4'b0101, write 4'b0100, column on cmd_addr) issues T_RCD cycles after the activate. cas_asserted is 1 in exactly that cycle.
- R8: After a read or write with keep_open = 0, the bank is precharged T_BURST cycles after the column command. With keep_open = 1, no precharge follows and the row stays open.
- R9: A read-for-merge issues a read command and leaves the row open whatever the value of keep_open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Pair populated and usable |
| cfg_base | input | PADDR_W | Window start, in high-address units |
| cfg_size | input | SIZE_W | Window length is 2^cfg_size units |
| sel | input | 1 | Speculative row-open request |
| sel_rd | input | 1 | Start a read transfer |
| sel_wr | input | 1 | Start a write transfer |
| sel_rmw | input | 1 | Start a read that keeps the row open |
| keep_open | input | 1 | Predictor hint: 1 keeps the row open after the transfer |
| bank_idx | input | BANK_W | Target bank |
| row_addr | input | ROW_W | Target row |
| col_addr | input | COL_W | Target column |
| hi_addr | input | PADDR_W | High address bits used for the window decode |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| cmd_bank | output | BANK_W | Bank of the current command |
| cmd_addr | output | ADDR_W | Row or column of the current command |
| cas_asserted | output | 1 | One-cycle strobe when a column command goes out |
| nxm | output | 1 | No pair matched the request |

## Verification
The window decode is swept across every high-address value, for two window positions and sizes and with the pair disabled. This separates an off-by-one at either window edge from a fault in the enable or in the size shift. The row logic is tried with a request to a closed bank, a repeat to the same row, a request for a different row and a withdrawn speculative open. Each of these patterns expects a different command, or none, so a wrong row compare or a missing precharge shows up at the pins. Reads, writes and read-for-merge are run with both hint values. The cycle distances between activate and column, between precharge and activate, and between column and the closing precharge are checked.

// File: rtl/rowctl_pkg.sv
package rowctl_pkg;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_ACT  = 3'd1,
    OP_PRE  = 3'd2,
    OP_RD   = 3'd3,
    OP_WR   = 3'd4
  } op_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } pins_t;

  function automatic pins_t op_pins(input op_e op);
    pins_t p;
    case (op)
      OP_ACT:  p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b1};
      OP_PRE:  p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
      OP_RD:   p = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b1};
      OP_WR:   p = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b0};
      default: p = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    endcase
    return p;
  endfunction

endpackage

// File: rtl/rowctl_range_dec.sv
module rowctl_range_dec #(
  parameter int PADDR_W = 10,
  parameter int SIZE_W  = 4
) (
  input  logic               en,
  input  logic [PADDR_W-1:0] base,
  input  logic [SIZE_W-1:0]  size,
  input  logic [PADDR_W-1:0] addr,
  output logic               hit
);
  localparam int SUM_W = PADDR_W + (1 << SIZE_W) + 1;

  logic [SUM_W-1:0] lo_w, lim_w, addr_w;

  always_comb begin
    lo_w   = SUM_W'(base);
    addr_w = SUM_W'(addr);
    lim_w  = lo_w + (SUM_W'(1) << size);
    hit    = en && (addr_w >= lo_w) && (addr_w < lim_w);
  end
endmodule

// File: rtl/rowctl_bank.sv
module rowctl_bank #(
  parameter int ROW_W   = 14,
  parameter int TMR_W   = 4,
  parameter int T_RCD   = 2,
  parameter int T_RP    = 2,
  parameter int T_BURST = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             do_act,
  input  logic             do_pre,
  input  logic             do_cas,
  input  logic             close_after,
  input  logic [ROW_W-1:0] row_in,
  output logic             is_open,
  output logic [ROW_W-1:0] open_row,
  output logic             idle,
  output logic             close_pend
);
  logic             open_q, open_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic             pend_q, pend_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic             upd_en;

  always_comb begin
    open_d = open_q;
    row_d  = row_q;
    pend_d = pend_q;
    tmr_d  = (tmr_q != '0) ? tmr_q - TMR_W'(1) : tmr_q;
    if (do_act) begin
      open_d = 1'b1;
      row_d  = row_in;
      tmr_d  = TMR_W'(T_RCD - 1);
    end
    if (do_pre) begin
      open_d = 1'b0;
      pend_d = 1'b0;
      tmr_d  = TMR_W'(T_RP - 1);
    end
    if (do_cas) begin
      pend_d = close_after;
      tmr_d  = TMR_W'(T_BURST - 1);
    end
    upd_en = do_act || do_pre || do_cas || (tmr_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      row_q  <= '0;
      pend_q <= 1'b0;
      tmr_q  <= '0;
    end else if (upd_en) begin
      open_q <= open_d;
      row_q  <= row_d;
      pend_q <= pend_d;
      tmr_q  <= tmr_d;
    end
  end

  assign is_open    = open_q;
  assign open_row   = row_q;
  assign idle       = (tmr_q == '0);
  assign close_pend = pend_q;
endmodule

// File: rtl/rowctl_sched.sv
module rowctl_sched
  import rowctl_pkg::*;
#(
  parameter int NBANK  = 4,
  parameter int BANK_W = 2,
  parameter int ROW_W  = 14
) (
  input  logic                        req,
  input  logic                        pair_hit,
  input  logic                        x_rd,
  input  logic                        x_wr,
  input  logic                        x_rmw,
  input  logic                        keep_open,
  input  logic [BANK_W-1:0]           bank_idx,
  input  logic [ROW_W-1:0]            row_in,
  input  logic [NBANK-1:0]            bank_open,
  input  logic [NBANK-1:0][ROW_W-1:0] bank_row,
  input  logic [NBANK-1:0]            bank_idle,
  input  logic [NBANK-1:0]            bank_pend,
  output op_e                         op,
  output logic [BANK_W-1:0]           op_bank,
  output logic                        close_after
);
  logic              cl_found;
  logic [BANK_W-1:0] cl_bank;
  logic              x_any;

  always_comb begin
    cl_found = 1'b0;
    cl_bank  = '0;
    for (int i = NBANK - 1; i >= 0; i--) begin
      if (bank_pend[i] && bank_idle[i]) begin
        cl_found = 1'b1;
        cl_bank  = BANK_W'(i);
      end
    end
  end

  always_comb begin
    x_any       = x_rd || x_wr || x_rmw;
    op          = OP_NONE;
    op_bank     = bank_idx;
    close_after = 1'b0;
    if (cl_found) begin
      op      = OP_PRE;
      op_bank = cl_bank;
    end else if (req && pair_hit && bank_idle[bank_idx]) begin
      if (!bank_open[bank_idx]) begin
        op = OP_ACT;
      end else if (bank_row[bank_idx] != row_in) begin
        op = OP_PRE;
      end else if (x_any) begin
        op          = (x_rd || x_rmw) ? OP_RD : OP_WR;
        close_after = !x_rmw && !keep_open;
      end
    end
  end
endmodule

// File: rtl/sdram_row_launch.sv
module sdram_row_launch
  import rowctl_pkg::*;
#(
  parameter  int NBANK   = 4,
  parameter  int ROW_W   = 14,
  parameter  int COL_W   = 10,
  parameter  int PADDR_W = 10,
  parameter  int SIZE_W  = 4,
  parameter  int TMR_W   = 4,
  parameter  int T_RCD   = 2,
  parameter  int T_RP    = 2,
  parameter  int T_BURST = 4,
  localparam int BANK_W  = (NBANK > 1) ? $clog2(NBANK) : 1,
  localparam int ADDR_W  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_en,
  input  logic [PADDR_W-1:0] cfg_base,
  input  logic [SIZE_W-1:0]  cfg_size,
  input  logic               sel,
  input  logic               sel_rd,
  input  logic               sel_wr,
  input  logic               sel_rmw,
  input  logic               keep_open,
  input  logic [BANK_W-1:0]  bank_idx,
  input  logic [ROW_W-1:0]   row_addr,
  input  logic [COL_W-1:0]   col_addr,
  input  logic [PADDR_W-1:0] hi_addr,
  output logic               cs_n,
  output logic               ras_n,
  output logic               cas_n,
  output logic               we_n,
  output logic [BANK_W-1:0]  cmd_bank,
  output logic [ADDR_W-1:0]  cmd_addr,
  output logic               cas_asserted,
  output logic               nxm
);
  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_n_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_sync <= rst_meta_q;
    end
  end

  logic                        pair_hit, req;
  logic [NBANK-1:0]            b_open, b_idle, b_pend;
  logic [NBANK-1:0][ROW_W-1:0] b_row;
  op_e                         op;
  logic [BANK_W-1:0]           op_bank;
  logic                        close_after;

  assign req = sel || sel_rd || sel_wr || sel_rmw;

  rowctl_range_dec #(.PADDR_W(PADDR_W), .SIZE_W(SIZE_W)) u_dec (
    .en(cfg_en), .base(cfg_base), .size(cfg_size), .addr(hi_addr), .hit(pair_hit)
  );

  rowctl_sched #(.NBANK(NBANK), .BANK_W(BANK_W), .ROW_W(ROW_W)) u_sched (
    .req(req), .pair_hit(pair_hit), .x_rd(sel_rd), .x_wr(sel_wr), .x_rmw(sel_rmw),
    .keep_open(keep_open), .bank_idx(bank_idx), .row_in(row_addr),
    .bank_open(b_open), .bank_row(b_row), .bank_idle(b_idle), .bank_pend(b_pend),
    .op(op), .op_bank(op_bank), .close_after(close_after)
  );

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic mine;
    assign mine = (op_bank == BANK_W'(g));
    rowctl_bank #(
      .ROW_W(ROW_W), .TMR_W(TMR_W), .T_RCD(T_RCD), .T_RP(T_RP), .T_BURST(T_BURST)
    ) u_bank (
      .clk(clk), .rst_n(rst_n_sync),
      .do_act(mine && op == OP_ACT),
      .do_pre(mine && op == OP_PRE),
      .do_cas(mine && (op == OP_RD || op == OP_WR)),
      .close_after(close_after), .row_in(row_addr),
      .is_open(b_open[g]), .open_row(b_row[g]), .idle(b_idle[g]), .close_pend(b_pend[g])
    );
  end

  // output stage
  pins_t             pins_d, pins_q;
  logic [ADDR_W-1:0] addr_d, addr_q;
  logic [BANK_W-1:0] bank_q;
  logic              cas_d, cas_q, nxm_d, nxm_q;

  always_comb begin
    pins_d = op_pins(op);
    cas_d  = (op == OP_RD) || (op == OP_WR);
    nxm_d  = req && !pair_hit;
    if (op == OP_ACT)  addr_d = ADDR_W'(row_addr);
    else if (cas_d)    addr_d = ADDR_W'(col_addr);
    else               addr_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      pins_q <= '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
      addr_q <= '0;
      bank_q <= '0;
      cas_q  <= 1'b0;
      nxm_q  <= 1'b0;
    end else begin
      pins_q <= pins_d;
      addr_q <= addr_d;
      bank_q <= op_bank;
      cas_q  <= cas_d;
      nxm_q  <= nxm_d;
    end
  end

  assign cs_n         = pins_q.cs_n;
  assign ras_n        = pins_q.ras_n;
  assign cas_n        = pins_q.cas_n;
  assign we_n         = pins_q.we_n;
  assign cmd_addr     = addr_q;
  assign cmd_bank     = bank_q;
  assign cas_asserted = cas_q;
  assign nxm          = nxm_q;
endmodule

// File: rtl/rowctl_chk.sv
module rowctl_chk #(
  parameter int BANK_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [BANK_W-1:0] cmd_bank,
  input logic              cas_asserted,
  input logic              nxm,
  input logic              sel_rd,
  input logic              sel_wr,
  input logic              sel_rmw
);
  logic is_act, is_pre, is_col;
  assign is_act = !cs_n && !ras_n && cas_n && we_n;
  assign is_pre = !cs_n && !ras_n && cas_n && !we_n;
  assign is_col = !cs_n && ras_n && !cas_n;

  // R1
  desel_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (ras_n && cas_n && we_n));

  // R7
  act_to_col_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |=> !(is_col && cmd_bank == $past(cmd_bank)));

  // R5
  pre_to_act_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |=> !(is_act && cmd_bank == $past(cmd_bank)));

  // R6
  strobe_needs_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel_rd || sel_wr || sel_rmw) |=> !cas_asserted);

  // R7
  strobe_on_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cas_asserted |-> is_col);

  // R7
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cas_asserted |=> !cas_asserted);

  // R2
  nxm_no_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nxm |-> !cas_asserted);
endmodule

bind sdram_row_launch rowctl_chk #(.BANK_W(BANK_W)) u_rowctl_chk (
  .clk(clk), .rst_n(rst_n_sync), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
  .cmd_bank(cmd_bank), .cas_asserted(cas_asserted), .nxm(nxm),
  .sel_rd(sel_rd), .sel_wr(sel_wr), .sel_rmw(sel_rmw)
);

// File: tb/test_sdram_row_launch.sv
`timescale 1ns/1ps
module test_sdram_row_launch;
  localparam int P_DESEL = 4'b1111;
  localparam int P_ACT   = 4'b0011;
  localparam int P_PRE   = 4'b0010;
  localparam int P_RD    = 4'b0101;
  localparam int P_WR    = 4'b0100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_en, sel, sel_rd, sel_wr, sel_rmw, keep_open;
  logic [9:0]  cfg_base, hi_addr;
  logic [3:0]  cfg_size;
  logic [1:0]  bank_idx;
  logic [13:0] row_addr;
  logic [9:0]  col_addr;
  logic        cs_n, ras_n, cas_n, we_n, cas_asserted, nxm;
  logic [1:0]  cmd_bank;
  logic [13:0] cmd_addr;
  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  sdram_row_launch i_sdram_row_launch (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_base(cfg_base), .cfg_size(cfg_size),
    .sel(sel), .sel_rd(sel_rd), .sel_wr(sel_wr), .sel_rmw(sel_rmw), .keep_open(keep_open),
    .bank_idx(bank_idx), .row_addr(row_addr), .col_addr(col_addr), .hi_addr(hi_addr),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd_bank(cmd_bank),
    .cmd_addr(cmd_addr), .cas_asserted(cas_asserted), .nxm(nxm)
  );

  function automatic int pins();
    return int'({cs_n, ras_n, cas_n, we_n});
  endfunction

  task automatic chk(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic drop();
    sel = 0; sel_rd = 0; sel_wr = 0; sel_rmw = 0;
  endtask

  task automatic idle_run(input string tag, input int n);
    for (int i = 0; i < n; i++) begin
      tick();
      chk(tag, "idle pins", pins(), P_DESEL);
      chk(tag, "idle strobe", int'(cas_asserted), 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    cfg_en = 1; cfg_base = 0; cfg_size = 4; hi_addr = 0;
    keep_open = 0; bank_idx = 0; row_addr = 0; col_addr = 0;
    drop();
    repeat (3) tick();
    // R1 during reset
    chk("R1", "reset pins", pins(), P_DESEL);
    chk("R1", "reset strobe", int'(cas_asserted), 0);
    chk("R1", "reset nxm", int'(nxm), 0);
    rst_n = 1;
    repeat (4) tick();
    chk("R1", "post-reset pins", pins(), P_DESEL);
    chk("R1", "post-reset nxm", int'(nxm), 0);

    // R3 open closed bank, R4 repeat hits
    bank_idx = 1; row_addr = 14'h123; sel = 1;
    tick();
    chk("R3", "act pins", pins(), P_ACT);
    chk("R3", "act bank", int'(cmd_bank), 1);
    chk("R3", "act row", int'(cmd_addr), 'h123);
    tick();
    chk("R4", "hit pins", pins(), P_DESEL);
    tick();
    chk("R4", "hit pins again", pins(), P_DESEL);
    drop();

    // R7 read before row open, keep open (R8)
    bank_idx = 2; row_addr = 14'h55; col_addr = 10'h3A; keep_open = 1;
    sel = 1; sel_rd = 1;
    tick();
    chk("R7", "act first", pins(), P_ACT);
    tick();
    chk("R7", "wait pins", pins(), P_DESEL);
    chk("R7", "wait strobe", int'(cas_asserted), 0);
    tick();
    chk("R7", "read pins", pins(), P_RD);
    chk("R7", "read strobe", int'(cas_asserted), 1);
    chk("R7", "read col", int'(cmd_addr), 'h3A);
    chk("R7", "read bank", int'(cmd_bank), 2);
    drop();
    idle_run("R8", 8);

    // R8 write with close hint
    keep_open = 0; col_addr = 10'h11; sel = 1; sel_wr = 1;
    tick();
    chk("R8", "write pins", pins(), P_WR);
    chk("R8", "write strobe", int'(cas_asserted), 1);
    chk("R8", "write col", int'(cmd_addr), 'h11);
    drop();
    idle_run("R8", 3);
    tick();
    chk("R8", "close pre pins", pins(), P_PRE);
    chk("R8", "close pre bank", int'(cmd_bank), 2);
    repeat (2) tick();
    sel = 1;
    tick();
    chk("R8", "reopen after close", pins(), P_ACT);
    drop();
    repeat (3) tick();

    // R5 row conflict on bank 1
    bank_idx = 1; row_addr = 14'h200; sel = 1;
    tick();
    chk("R5", "conflict pre", pins(), P_PRE);
    chk("R5", "conflict bank", int'(cmd_bank), 1);
    tick();
    chk("R5", "rp wait", pins(), P_DESEL);
    tick();
    chk("R5", "new act", pins(), P_ACT);
    chk("R5", "new row", int'(cmd_addr), 'h200);
    drop();
    repeat (2) tick();

    // R9 read-for-merge ignores close hint
    bank_idx = 3; row_addr = 14'h7; col_addr = 10'h2C; keep_open = 0;
    sel = 1; sel_rmw = 1;
    tick();
    chk("R9", "act", pins(), P_ACT);
    tick();
    chk("R9", "wait", pins(), P_DESEL);
    tick();
    chk("R9", "read pins", pins(), P_RD);
    chk("R9", "read strobe", int'(cas_asserted), 1);
    drop();
    idle_run("R9", 8);
    sel = 1;
    tick();
    chk("R9", "row still open", pins(), P_DESEL);
    drop();
    tick();

    // R6 speculative open withdrawn
    bank_idx = 0; row_addr = 14'h10; sel = 1;
    tick();
    chk("R6", "spec act", pins(), P_ACT);
    drop();
    idle_run("R6", 5);

    // R2 decode sweeps (bank 0 row 0x10 already open: matched requests issue nothing)
    sel = 1;
    cfg_base = 16; cfg_size = 3;
    for (int h = 0; h < 64; h++) begin
      hi_addr = 10'(h);
      tick();
      chk("R2", "nxm win16x8", int'(nxm), (h >= 16 && h < 24) ? 0 : 1);
      chk("R2", "no cmd", pins(), P_DESEL);
    end
    cfg_base = 40; cfg_size = 0;
    for (int h = 32; h < 48; h++) begin
      hi_addr = 10'(h);
      tick();
      chk("R2", "nxm win40x1", int'(nxm), (h == 40) ? 0 : 1);
    end
    cfg_en = 0; cfg_base = 0; cfg_size = 4;
    for (int h = 0; h < 16; h++) begin
      hi_addr = 10'(h);
      tick();
      chk("R2", "nxm disabled", int'(nxm), 1);
      chk("R2", "no cmd disabled", pins(), P_DESEL);
    end
    drop();
    tick();
    chk("R2", "nxm without request", int'(nxm), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule